// File: doc/BRIEF.md
# Composite Sync and Blanking Generator

This block sits between a CRT controller and the video output stage. It takes the controller's raw horizontal and vertical sync pulses, sampled once per character clock, and builds the sync pulse a monitor expects. The horizontal pulse it emits does not copy the raw pulse. It is a window that opens two characters into the raw pulse and closes at most four characters later. The vertical pulse is built the same way, from a count of lines that starts at the raw vertical sync.

The two active-high sync terms are merged by XNOR into one active-low composite sync. A force-black signal tells the pixel path to emit black during every raw horizontal sync and for a fixed run of lines after each raw vertical sync starts. The run holds its full length even when the raw vertical pulse is much shorter. The block also strobes `mode_apply` at the point inside horizontal sync where a pending graphics-mode change should take effect.

Top module: `csync_blank_gen`

## Requirements
- R1: After reset, `csync_n` is 1, `force_black` is 0 and `mode_apply` is 0.
- R2: State advances only on clock edges where `char_en` is 1. With `char_en` at 0, the inputs have no effect and `csync_n` and `force_black` hold.
- R3: A character counter restarts on the first tick with `hsync_in` high and counts every tick while it stays high. The horizontal term is active after the 2nd through the 5th such tick (4 characters), so `csync_n` is 0 there when no vertical term is active.
- R4: When `hsync_in` falls before the 6th character, the horizontal term ends at the tick that sees it low.
- R5: `mode_apply` is high for exactly one clock, after the tick on which the character counter reaches 2, and only if `mode_req` is 1 on that tick. A raw hsync of only one character never produces it.
- R6: `force_black` is 1 after every tick that samples `hsync_in` high.
- R7: A line counter restarts at 0 on the tick where `vsync_in` rises and counts each hsync end (a tick that samples `hsync_in` low after a high one). The vertical term is active while the count is 2 through 5. A new vsync rise restarts the count.
- R8: `force_black` stays 1 from the vsync-rise tick until the 26th hsync end after it, whether or not `vsync_in` is still high.
- R9: `csync_n` is the XNOR of the two terms: 1 when neither or both are active, 0 when exactly one is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_en | input | 1 | Character clock enable, one tick per character |
| hsync_in | input | 1 | Raw horizontal sync from the CRT controller, active high |
| vsync_in | input | 1 | Raw vertical sync from the CRT controller, active high |
| mode_req | input | 1 | A graphics-mode change is pending |
| csync_n | output | 1 | Composite sync to the monitor, active low |
| force_black | output | 1 | Force the pixel output to black |
| mode_apply | output | 1 | One-clock strobe to apply the pending mode |

## Verification
The bench builds the block with its default parameters: a window from character 2 to 6, a vertical window from line 2 to 6, a 26-line blanking run, and the vertical term not gated by the raw vsync. Lines in the bench are only two characters long, so the whole 26-line run and its end can be checked in a few hundred clocks. The vertical term can also be overlapped with a wide hsync to reach the case where both terms are active. Raw vsync is dropped after three lines, so the bench can show that the blanking length does not depend on the raw pulse width.

// File: rtl/csbg_pkg.sv
`timescale 1ns/1ps
package csbg_pkg;

   // Active-high sync windows produced by the two counters
   typedef struct packed {
      logic hs;
      logic vs;
   } sync_terms_t;

   // Bits needed to hold values 0..max_val
   function automatic int cnt_bits(input int max_val);
      int b;
      b = 1;
      while ((1 << b) <= max_val) b++;
      return b;
   endfunction

endpackage

// File: rtl/csbg_hwin.sv
`timescale 1ns/1ps
// Horizontal window: counts characters inside raw hsync, opens the
// horizontal sync term and times the mode-change strobe.
module csbg_hwin #(
   parameter int HS_START = 2,
   parameter int HS_STOP  = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic hs_raw,
   input  logic mode_req,
   output logic hs_seen,
   output logic hs_term,
   output logic hs_end,
   output logic mode_apply
);
   localparam int HW = csbg_pkg::cnt_bits(HS_STOP + 1);
   localparam logic [HW-1:0] H_ON   = HW'(HS_START);
   localparam logic [HW-1:0] H_OFF  = HW'(HS_STOP);
   localparam logic [HW-1:0] H_MAX  = {HW{1'b1}};
   localparam logic [HW-1:0] H_ONE  = HW'(1);

   logic [HW-1:0] hcnt;
   logic [HW-1:0] hcnt_nxt;
   logic          hs_q;

   // First character of a fresh pulse counts as 1; saturate on long pulses
   always_comb begin
      if (!hs_q)
         hcnt_nxt = H_ONE;
      else if (hcnt == H_MAX)
         hcnt_nxt = hcnt;
      else
         hcnt_nxt = hcnt + H_ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hcnt       <= '0;
         hs_q       <= 1'b0;
         mode_apply <= 1'b0;
      end else begin
         mode_apply <= 1'b0;
         if (tick) begin
            hs_q <= hs_raw;
            if (hs_raw) begin
               hcnt <= hcnt_nxt;
               if (hcnt_nxt == H_ON)
                  mode_apply <= mode_req;
            end else begin
               hcnt <= '0;
            end
         end
      end
   end

   assign hs_seen = hs_q;
   assign hs_term = (hcnt >= H_ON) && (hcnt < H_OFF);
   assign hs_end  = tick && hs_q && !hs_raw;

endmodule

// File: rtl/csbg_vwin.sv
`timescale 1ns/1ps
// Vertical window: counts hsync ends from the vsync rise, holds the
// blanking run and opens the vertical sync term.
module csbg_vwin #(
   parameter int VS_START    = 2,
   parameter int VS_STOP     = 6,
   parameter int BLANK_LINES = 26,
   parameter bit GATE_RAW    = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic vs_raw,
   input  logic hs_end,
   output logic vs_term,
   output logic vblank
);
   localparam int VW = csbg_pkg::cnt_bits(BLANK_LINES);
   localparam logic [VW-1:0] V_ON   = VW'(VS_START);
   localparam logic [VW-1:0] V_OFF  = VW'(VS_STOP);
   localparam logic [VW-1:0] V_LAST = VW'(BLANK_LINES);
   localparam logic [VW-1:0] V_ONE  = VW'(1);

   logic [VW-1:0] vcnt;
   logic [VW-1:0] vcnt_nxt;
   logic          vs_q;
   logic          in_win;

   assign vcnt_nxt = vcnt + V_ONE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vcnt   <= '0;
         vs_q   <= 1'b0;
         vblank <= 1'b0;
      end else if (tick) begin
         vs_q <= vs_raw;
         if (vs_raw && !vs_q) begin
            vcnt   <= '0;
            vblank <= 1'b1;
         end else if (vblank && hs_end) begin
            vcnt <= vcnt_nxt;
            if (vcnt_nxt == V_LAST)
               vblank <= 1'b0;
         end
      end
   end

   assign in_win = vblank && (vcnt >= V_ON) && (vcnt < V_OFF);

   generate
      if (GATE_RAW) begin : g_gated
         assign vs_term = in_win && vs_q;
      end else begin : g_free
         assign vs_term = in_win;
      end
   endgenerate

endmodule

// File: rtl/csbg_merge.sv
`timescale 1ns/1ps
// Output stage: composite sync by XNOR and the force-black combine.
module csbg_merge (
   input  csbg_pkg::sync_terms_t terms,
   input  logic hs_seen,
   input  logic vblank,
   output logic csync_n,
   output logic force_black
);
   assign csync_n     = terms.hs ~^ terms.vs;
   assign force_black = hs_seen | vblank;
endmodule

// File: rtl/csync_blank_gen.sv
`timescale 1ns/1ps
module csync_blank_gen #(
   parameter int HS_START    = 2,
   parameter int HS_STOP     = 6,
   parameter int VS_START    = 2,
   parameter int VS_STOP     = 6,
   parameter int BLANK_LINES = 26,
   parameter bit VS_GATE_RAW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic char_en,
   input  logic hsync_in,
   input  logic vsync_in,
   input  logic mode_req,
   output logic csync_n,
   output logic force_black,
   output logic mode_apply
);
   // Elaboration-time parameter checks
   generate
      if (HS_START < 1 || HS_STOP <= HS_START) begin : g_bad_h
         $error("csync_blank_gen: horizontal window must satisfy 1 <= start < stop");
      end
      if (VS_START < 0 || VS_STOP <= VS_START) begin : g_bad_v
         $error("csync_blank_gen: vertical window must satisfy 0 <= start < stop");
      end
      if (BLANK_LINES < VS_STOP) begin : g_bad_b
         $error("csync_blank_gen: blanking run shorter than the vertical window");
      end
   endgenerate

   logic hs_term;
   logic vs_term;
   logic hs_seen;
   logic hs_end;
   logic vblank;
   csbg_pkg::sync_terms_t terms;

   csbg_hwin #(
      .HS_START (HS_START),
      .HS_STOP  (HS_STOP)
   ) u_hwin (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (char_en),
      .hs_raw     (hsync_in),
      .mode_req   (mode_req),
      .hs_seen    (hs_seen),
      .hs_term    (hs_term),
      .hs_end     (hs_end),
      .mode_apply (mode_apply)
   );

   csbg_vwin #(
      .VS_START    (VS_START),
      .VS_STOP     (VS_STOP),
      .BLANK_LINES (BLANK_LINES),
      .GATE_RAW    (VS_GATE_RAW)
   ) u_vwin (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (char_en),
      .vs_raw  (vsync_in),
      .hs_end  (hs_end),
      .vs_term (vs_term),
      .vblank  (vblank)
   );

   assign terms.hs = hs_term;
   assign terms.vs = vs_term;

   csbg_merge u_merge (
      .terms       (terms),
      .hs_seen     (hs_seen),
      .vblank      (vblank),
      .csync_n     (csync_n),
      .force_black (force_black)
   );

endmodule

// File: rtl/csbg_checker.sv
`timescale 1ns/1ps
module csbg_checker (
   input logic clk,
   input logic rst_n,
   input logic char_en,
   input logic hsync_in,
   input logic mode_req,
   input logic csync_n,
   input logic force_black,
   input logic mode_apply,
   input logic hs_term,
   input logic vs_term
);
   // R2
   hold_wo_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !char_en |=> $stable(csync_n) && $stable(force_black));

   // R5
   apply_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_apply |=> !mode_apply);

   // R5
   apply_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_apply |-> $past(char_en && mode_req && hsync_in));

   // R6
   hs_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      char_en && hsync_in |=> force_black);

   // R3
   hterm_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_term |-> force_black);

   // R8
   vterm_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vs_term |-> force_black);
endmodule

bind csync_blank_gen csbg_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .char_en     (char_en),
   .hsync_in    (hsync_in),
   .mode_req    (mode_req),
   .csync_n     (csync_n),
   .force_black (force_black),
   .mode_apply  (mode_apply),
   .hs_term     (hs_term),
   .vs_term     (vs_term)
);

// File: tb/csync_blank_gen_bench.sv
`timescale 1ns/1ps
module csync_blank_gen_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic char_en = 1'b0;
   logic hsync_in = 1'b0;
   logic vsync_in = 1'b0;
   logic mode_req = 1'b0;
   logic csync_n, force_black, mode_apply;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   csync_blank_gen u_csync_blank_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .char_en     (char_en),
      .hsync_in    (hsync_in),
      .vsync_in    (vsync_in),
      .mode_req    (mode_req),
      .csync_n     (csync_n),
      .force_black (force_black),
      .mode_apply  (mode_apply)
   );

   // {hsync, vsync, mode_req, exp csync_n, exp force_black, exp mode_apply}
   localparam int NV = 21;
   localparam logic [5:0] VEC [NV] = '{
      6'b001100,                                  // idle
      6'b101110, 6'b101011, 6'b101010, 6'b101010, // 8-char hsync, R3 window
      6'b101010, 6'b101110, 6'b101110, 6'b101110,
      6'b001100,
      6'b101110, 6'b101011, 6'b101010, 6'b001100, // 3-char hsync, R4 early end
      6'b101110, 6'b001100,                       // 1-char hsync, no strobe
      6'b100110, 6'b100010, 6'b100010, 6'b100010, // no pending mode
      6'b000100
   };

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // One character: drive inputs, pulse char_en for one clock, sample after
   task automatic tick(input logic h, input logic v, input logic m);
      @(negedge clk);
      hsync_in = h; vsync_in = v; mode_req = m; char_en = 1'b1;
      @(negedge clk);
      char_en = 1'b0;
   endtask

   task automatic line(input logic v);
      tick(1'b1, v, 1'b0);
      tick(1'b0, v, 1'b0);
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 csync_n", csync_n, 1'b1);
      chk("R1 force_black", force_black, 1'b0);
      chk("R1 mode_apply", mode_apply, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         tick(VEC[i][5], VEC[i][4], VEC[i][3]);
         chk("R3/R9 csync_n", csync_n, VEC[i][2]);
         chk("R6 force_black", force_black, VEC[i][1]);
         chk("R5 mode_apply", mode_apply, VEC[i][0]);
      end

      // R5 strobe lasts one clock
      tick(1'b1, 1'b0, 1'b1);
      tick(1'b1, 1'b0, 1'b1);
      chk("R5 strobe", mode_apply, 1'b1);
      @(negedge clk);
      chk("R5 single clock", mode_apply, 1'b0);
      // R2: no tick, inputs change, outputs hold
      hsync_in = 1'b0; vsync_in = 1'b1;
      repeat (4) @(negedge clk);
      chk("R2 csync_n hold", csync_n, 1'b0);
      chk("R2 force_black hold", force_black, 1'b1);
      // R4 falling hsync ends the term
      tick(1'b0, 1'b0, 1'b0);
      chk("R4 csync_n", csync_n, 1'b1);
      chk("R4 force_black", force_black, 1'b0);

      // R7 / R8: vsync rise, short raw vsync, 28 two-character lines
      tick(1'b0, 1'b1, 1'b0);
      chk("R8 blank at rise", force_black, 1'b1);
      chk("R7 count 0", csync_n, 1'b1);
      for (int n = 1; n <= 28; n++) begin
         logic v;
         logic blank;
         logic vs;
         v = (n <= 3);
         tick(1'b1, v, 1'b0);
         chk("R6 line hsync", force_black, 1'b1);
         tick(1'b0, v, 1'b0);
         blank = (n < 26);
         vs = blank && (n >= 2) && (n < 6);
         chk("R7 vertical term", csync_n, !vs);
         chk("R8 blanking run", force_black, blank);
      end

      // R9 overlap of both terms, then R7 restart
      tick(1'b0, 1'b0, 1'b0);
      tick(1'b0, 1'b1, 1'b0);
      line(1'b1);
      line(1'b1);
      chk("R7 count 2", csync_n, 1'b0);
      tick(1'b1, 1'b1, 1'b0);
      chk("R9 vertical only", csync_n, 1'b0);
      tick(1'b1, 1'b1, 1'b0);
      chk("R9 both active", csync_n, 1'b1);
      tick(1'b1, 1'b1, 1'b0);
      chk("R9 both active", csync_n, 1'b1);
      tick(1'b0, 1'b0, 1'b0);
      chk("R9 vertical only after end", csync_n, 1'b0);
      tick(1'b0, 1'b1, 1'b0);
      chk("R7 restart count", csync_n, 1'b1);
      chk("R8 restart blank", force_black, 1'b1);
      line(1'b1);
      chk("R7 restart count 1", csync_n, 1'b1);
      line(1'b0);
      chk("R7 restart count 2", csync_n, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule